// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external 32K x 8 asynchronous static RAM. It turns single-word read and write requests into strobe sequences whose phase lengths meet the memory's timing. The host raises a request with a read/write select, a 15-bit address and 8-bit write data while the ready flag is high. For a read, the block later returns the captured byte with a one-cycle valid pulse.

Each timing limit of the memory is a parameter in nanoseconds, and so is the clock period. The block converts every limit to a clock count by dividing by the period and rounding up, with a floor of one clock. All memory-side pins come from registers. Writes are controlled by the write strobe, and output enable stays high for the whole write. The data bus toward the memory is a split output value, output enable and input value. The pad cells that merge them sit outside the block. The bus is turned around before the block drives it and released after the write strobe has ended.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip enable, output enable and write enable (all active low) are high, the data output enable is low, ready is high and read-valid is low.
- R2: A read holds chip enable and output enable low and write enable high for exactly ceil(tAA/period) clocks (3 at the defaults), with the address stable throughout.
- R3: Read data is sampled on the last clock of the access. Read-valid is high for exactly one cycle, in the same cycle that chip enable and output enable return high, and read data carries the stored byte in that cycle.
- R4: A write pulls chip enable and write enable low on the same clock edge. Output enable stays high for the whole write, and the data output enable is low in the first write cycle.
- R5: The data output enable rises only after write enable has been low for ceil(tWHZ/period) clocks (at least tWHZ ns). It is never high while output enable is low.
- R6: Write enable stays low for at least ceil(tWP/period) and ceil(tAW/period) clocks (3 at the defaults). Data is driven for at least ceil(tDW/period) clocks (2 at the defaults) before write enable rises.
- R7: After write enable rises, chip enable, the address, the data value and the data output enable hold for one more clock. Then chip enable rises and the data output enable falls on the same edge.
- R8: Ready falls on the edge that accepts a request. It stays low for max(ceil(tAA), ceil(tRC)) clocks on a read and max(write body, ceil(tWC)) clocks on a write (3 and 4 at the defaults). A request made while ready is low is dropped, not queued. A request held high is taken again on the first edge at which ready is seen high.
- R9: we_i = 1 selects a write and we_i = 0 a read. Every location written, including address 0 and address 32767, reads back the byte last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | High when a new request can be taken |
| rdata_o | output | 8 | Captured read data |
| rvalid_o | output | 1 | One-cycle pulse marking rdata_o valid |
| sram_ce_no | output | 1 | Memory chip enable, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write enable, active low |
| sram_addr_o | output | 15 | Memory address bus |
| sram_dq_o | output | 8 | Data value toward the memory |
| sram_dq_oe_o | output | 1 | Drive enable for the data pins |
| sram_dq_i | input | 8 | Data value read from the pins |

## Verification
The read-valid pulse, the release of the strobes and the return of ready all fall on one edge. A request that is still pending at that edge could be taken one cycle early. The bench holds a read request high across two full read cycles. It expects exactly two valid pulses, each with the correct byte, and exactly one idle cycle with chip enable high between the two accesses. A second collision is a request issued in the middle of a busy write. After the write completes, chip enable must stay high, and a later read of the targeted address must return its old contents.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_TA,
    ST_WR_DRV,
    ST_WR_HOLD,
    ST_RECOV
  } ctl_state_e;

  // ceil(t/per), never below one clock
  function automatic int ns_to_cyc(input int t_ns, input int per_ns);
    int c;
    c = (t_ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end

  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);  // R3

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 15,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_AA_NS       = 15,
  parameter int T_RC_NS       = 15,
  parameter int T_WC_NS       = 15,
  parameter int T_WP_NS       = 11,
  parameter int T_AW_NS       = 12,
  parameter int T_DW_NS       = 8,
  parameter int T_WHZ_NS      = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          sram_ce_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int AA_CYC  = ns_to_cyc(T_AA_NS,  CLK_PERIOD_NS);
  localparam int RC_CYC  = ns_to_cyc(T_RC_NS,  CLK_PERIOD_NS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS,  CLK_PERIOD_NS);
  localparam int WP_CYC  = ns_to_cyc(T_WP_NS,  CLK_PERIOD_NS);
  localparam int AWR_CYC = ns_to_cyc(T_AW_NS,  CLK_PERIOD_NS);
  localparam int DS_CYC  = ns_to_cyc(T_DW_NS,  CLK_PERIOD_NS);
  localparam int TA_CYC  = ns_to_cyc(T_WHZ_NS, CLK_PERIOD_NS);
  // clocks of driven data before WE rises; also stretches WE to tWP / tAW
  localparam int DRV_CYC = imax(imax(DS_CYC, 1), imax(WP_CYC - TA_CYC, AWR_CYC - TA_CYC));
  localparam int RD_BUSY = imax(AA_CYC, RC_CYC);
  localparam int RD_PAD  = RD_BUSY - AA_CYC;
  localparam int WR_BODY = TA_CYC + DRV_CYC + 1;
  localparam int WR_PAD  = imax(WC_CYC, WR_BODY) - WR_BODY;
  localparam int MAXC    = imax(imax(WR_BODY, RD_BUSY), WC_CYC);
  localparam int TW      = $clog2(MAXC + 1);

  ctl_state_e    state_q;
  logic          ready_q, ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dq_q;
  logic          accept, t_done, t_load, cap;
  logic [TW-1:0] t_val;

  assign accept = req_i && ready_q;
  assign cap    = (state_q == ST_RD) && t_done;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        t_load = 1'b1;
        t_val  = we_i ? TW'(TA_CYC - 1) : TW'(AA_CYC - 1);
      end
      ST_RD: if (t_done && RD_PAD > 0) begin
        t_load = 1'b1;
        t_val  = TW'(RD_PAD - 1);
      end
      ST_WR_TA: if (t_done) begin
        t_load = 1'b1;
        t_val  = TW'(DRV_CYC - 1);
      end
      ST_WR_HOLD: if (WR_PAD > 0) begin
        t_load = 1'b1;
        t_val  = TW'(WR_PAD - 1);
      end
      default: ;
    endcase
  end

  sram_phase_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      dq_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= addr_i;
          ce_n_q  <= 1'b0;
          ready_q <= 1'b0;
          if (we_i) begin
            we_n_q  <= 1'b0;
            dq_q    <= wdata_i;
            state_q <= ST_WR_TA;
          end else begin
            oe_n_q  <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: if (t_done) begin
          ce_n_q <= 1'b1;
          oe_n_q <= 1'b1;
          if (RD_PAD > 0) state_q <= ST_RECOV;
          else begin
            state_q <= ST_IDLE;
            ready_q <= 1'b1;
          end
        end
        ST_WR_TA: if (t_done) begin
          dq_oe_q <= 1'b1;  // memory output has turned off
          state_q <= ST_WR_DRV;
        end
        ST_WR_DRV: if (t_done) begin
          we_n_q  <= 1'b1;  // WE ends the write
          state_q <= ST_WR_HOLD;
        end
        ST_WR_HOLD: begin
          ce_n_q  <= 1'b1;
          dq_oe_q <= 1'b0;
          if (WR_PAD > 0) state_q <= ST_RECOV;
          else begin
            state_q <= ST_IDLE;
            ready_q <= 1'b1;
          end
        end
        ST_RECOV: if (t_done) begin
          state_q <= ST_IDLE;
          ready_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .dq_i     (sram_dq_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign ready_o      = ready_q;
  assign sram_ce_no   = ce_n_q;
  assign sram_oe_no   = oe_n_q;
  assign sram_we_no   = we_n_q;
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = dq_q;
  assign sram_dq_oe_o = dq_oe_q;

  // cycles of WE low, for the pulse-width check
  logic [TW-1:0] we_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      we_low_q <= '0;
    else if (!we_n_q) we_low_q <= we_low_q + 1'b1;
    else              we_low_q <= '0;
  end

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && !$past(sram_ce_no)) |-> $stable(sram_addr_o));  // R2
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (sram_oe_no && !sram_ce_no));  // R4
  AST_DQ_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (sram_oe_no && !sram_ce_no));  // R5
  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> !sram_dq_oe_o);  // R5
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_low_q >= TW'(WP_CYC)));  // R6
  AST_WE_END_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_dq_oe_o && !sram_ce_no && $stable(sram_dq_o) && $stable(sram_addr_o)));  // R7
  AST_CE_AFTER_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_ce_no) |-> $past(sram_we_no));  // R7
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);  // R8

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;

  localparam int PER = 5;
  localparam int T_AA = 15, T_RC = 15, T_WC = 15, T_WP = 11, T_AW = 12, T_DW = 8, T_WHZ = 5;

  function automatic int cyc(input int t);
    int c;
    c = (t + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_AA = cyc(T_AA);
  localparam int B_TA = cyc(T_WHZ);
  localparam int B_D  = mx(mx(cyc(T_DW), 1), mx(cyc(T_WP) - B_TA, cyc(T_AW) - B_TA));
  localparam int B_RD = mx(B_AA, cyc(T_RC));
  localparam int B_WR = mx(B_TA + B_D + 1, cyc(T_WC));

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready_o, rvalid_o, ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  rdata_o, dq_o;
  logic [7:0]  dq_i = 8'hEE;
  logic [14:0] sram_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0, model_on = 1'b0;

  sram_async_ctrl #(
    .CLK_PERIOD_NS(PER), .T_AA_NS(T_AA), .T_RC_NS(T_RC), .T_WC_NS(T_WC),
    .T_WP_NS(T_WP), .T_AW_NS(T_AW), .T_DW_NS(T_DW), .T_WHZ_NS(T_WHZ)
  ) u_sram_async_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n), .sram_addr_o(sram_addr),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural memory with timing checks
  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  realtime t_rd = 0, t_wef = 0, t_dq = 0, t_ad = 0;

  function automatic logic [7:0] mem_rd(input int a);
    if (mem.exists(a)) return mem[a];
    return 8'h5A;
  endfunction
  function automatic logic [7:0] ref_rd(input int a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return 8'h5A;
  endfunction

  always @(ce_n or oe_n or we_n or sram_addr) t_rd = $realtime;
  always @(sram_addr) t_ad = $realtime;
  always @(negedge we_n) t_wef = $realtime;
  always @(posedge dq_oe or dq_o) t_dq = $realtime;

  always @(posedge dq_oe)
    if (model_on)
      chk(!we_n && ($realtime - t_wef) >= T_WHZ, "R5 drive after WE low", int'($realtime - t_wef), T_WHZ);

  always @(posedge we_n)
    if (model_on && !ce_n) begin
      chk(($realtime - t_wef) >= T_WP, "R6 write pulse ns", int'($realtime - t_wef), T_WP);
      chk(dq_oe && ($realtime - t_dq) >= T_DW, "R6 data setup ns", int'($realtime - t_dq), T_DW);
      chk(($realtime - t_ad) >= T_AW, "R6 address to end of write ns", int'($realtime - t_ad), T_AW);
      chk(oe_n, "R4 OE high at end of write", int'(oe_n), 1);
      mem[int'(sram_addr)] = dq_o;
    end

  always @(negedge clk) begin
    if (model_on && !ce_n && !oe_n && we_n) begin
      dq_i = (($realtime - t_rd + 2.5) >= T_AA) ? mem_rd(int'(sram_addr)) : 8'hEE;
      if (dq_oe) chk(1'b0, "R5 bus contention", 1, 0);
    end else begin
      dq_i = 8'hEE;
    end
  end

  task automatic issue(input bit rw, input int a, input logic [7:0] d);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; we = rw; addr = 15'(a); wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && ready_o && !rvalid_o, "R1 pins in reset",
        {ce_n, oe_n, we_n, dq_oe, ready_o, rvalid_o}, 6'b111010);
    rst_ni = 1'b1;
    @(negedge clk);
    model_on = 1'b1;
    chk(ce_n && oe_n && we_n && !dq_oe && ready_o && !rvalid_o, "R1 pins after reset",
        {ce_n, oe_n, we_n, dq_oe, ready_o, rvalid_o}, 6'b111010);
  endtask

  task automatic wr_word(input int a, input logic [7:0] d);
    int busy = 0, wl = 0, dv = 0, dpre = 0, cl = 0, rv = 0;
    issue(1'b1, a, d);
    ref_mem[a] = d;
    chk(!ce_n && !we_n && oe_n && !dq_oe, "R4 first write cycle",
        {ce_n, we_n, oe_n, dq_oe}, 4'b0010);
    while (!ready_o && busy < 50) begin
      busy++;
      if (!we_n) wl++;
      if (dq_oe) dv++;
      if (dq_oe && !we_n) dpre++;
      if (!ce_n) cl++;
      if (rvalid_o) rv++;
      @(negedge clk);
    end
    chk(busy == B_WR, "R8 write busy clocks", busy, B_WR);
    chk(wl == B_TA + B_D, "R6 WE low clocks", wl, B_TA + B_D);
    chk(dpre == B_D, "R6 data driven before WE rise", dpre, B_D);
    chk(dv == B_D + 1, "R7 data driven clocks", dv, B_D + 1);
    chk(cl == B_TA + B_D + 1, "R7 CE low clocks", cl, B_TA + B_D + 1);
    chk(ce_n && !dq_oe && rv == 0, "R7 bus released", {ce_n, dq_oe}, 2'b10);
  endtask

  task automatic rd_word(input int a);
    int busy = 0, sl = 0, early = 0;
    logic [7:0] e;
    e = ref_rd(a);
    issue(1'b0, a, 8'h00);
    while (!ready_o && busy < 50) begin
      busy++;
      if (!ce_n && !oe_n && we_n) sl++;
      if (rvalid_o) early++;
      @(negedge clk);
    end
    chk(busy == B_RD, "R8 read busy clocks", busy, B_RD);
    chk(sl == B_AA && early == 0, "R2 read strobe clocks", sl, B_AA);
    chk(rvalid_o && ce_n && oe_n, "R3 valid with strobe release", {rvalid_o, ce_n, oe_n}, 3'b111);
    chk(rdata_o == e, "R9 read data", int'(rdata_o), int'(e));
    @(negedge clk);
    chk(!rvalid_o, "R3 valid is one cycle", int'(rvalid_o), 0);
  endtask

  task automatic t_write_then_read();
    wr_word(0, 8'h3C);
    wr_word(32767, 8'hC3);
    wr_word(15'h1234, 8'hA5);
    wr_word(15'h4000, 8'h96);
    wr_word(0, 8'h71);
    rd_word(0);
    rd_word(32767);
    rd_word(15'h1234);
    rd_word(15'h4000);
    rd_word(15'h0100);
  endtask

  task automatic t_held_request();
    int nv = 0, nce = 0, bad = 0;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 15'd32767;
    for (int i = 0; i < 2 * (B_RD + 1); i++) begin
      @(negedge clk);
      if (rvalid_o) begin
        nv++;
        if (rdata_o != ref_rd(32767)) bad++;
      end
      if (ce_n) nce++;
    end
    req = 1'b0;
    chk(nv == 2 && bad == 0, "R8 held request taken twice", nv, 2);
    chk(nce == 2, "R8 one idle clock between accesses", nce, 2);
  endtask

  task automatic t_busy_ignored();
    int extra = 0;
    wr_word(15'h2222, 8'h5C);
    issue(1'b1, 15'h3333, 8'h11);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 15'h2222; wdata = 8'hFF;
    @(negedge clk);
    req = 1'b0;
    while (!ready_o) @(negedge clk);
    ref_mem[15'h3333] = 8'h11;
    for (int i = 0; i < 4; i++) begin
      if (!ce_n) extra++;
      @(negedge clk);
    end
    chk(extra == 0, "R8 busy request not queued", extra, 0);
    rd_word(15'h2222);
    rd_word(15'h3333);
  endtask

  initial begin
    do_reset();
    t_write_then_read();
    t_held_request();
    t_busy_ignored();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule